// File: doc/BRIEF.md
# Serial Port Register and Flag Controller

This block is the processor-facing side of an asynchronous serial port. A host reaches eight byte-wide registers through a single-byte read/write strobe. The registers hold line configuration, control enables, a transmit holding byte, a status byte and the last received byte. The block owns every flag that ties the host to the line: transmit-buffer-empty, transmitter-idle, receive-full, and parity, framing and overrun errors. It drives four interrupt lines from those flags.

A separate frame engine does the bit timing. It gets a one-cycle `tx_load` strobe with the byte to send, and it reports each finished frame on `tx_done`. It delivers received bytes on `rx_valid`/`rx_byte` and line breaks on `rx_break`. Transmission is double-buffered. While the engine is busy with one frame, the host may park a second byte, and that byte goes out as soon as the frame finishes. A bus access and an engine event may arrive in the same cycle. The bus effect is applied first, then the engine event, and a hardware set of a flag wins over a clear in that cycle.

Top module: `sio_regs`

## Requirements
- R1: Register offsets are line mode 0, bit rate 1, control 2, transmit byte 3, status 4, receive byte 5, auxiliary A 6, auxiliary B 7. After reset they read 0x00, 0xFF, 0x00, 0xFF, 0x84, 0x00, 0x00, 0x00. Auxiliary A and B read back whatever was last written to them.
- R2: The status bits, from bit 7 down, are: buffer-empty (7), receive-full (6), overrun (5), framing (4), parity (3), idle (2), received multiprocessor bit (1), multiprocessor transmit bit (0). Bit 1 reads 0. Bit 0 holds the value last written. The control bits are: transmit irq enable (7), receive/error irq enable (6), transmit enable (5), receive enable (4), idle irq enable (2). Bits 3, 1 and 0 are stored only.
- R3: While transmit enable or receive enable is 1, writes to line mode or bit rate are ignored.
- R4: A control write with transmit enable set sets buffer-empty and idle. If transmit irq enable is also set, `irq_tx_empty` pulses for one cycle.
- R5: A transmit-byte write while idle is 1 pulses `tx_load` with that byte in the next cycle. It clears idle, leaves buffer-empty at 1, and pulses `irq_tx_empty` if transmit irq enable is set.
- R6: A transmit-byte write while idle is 0 only clears buffer-empty, with no `tx_load`.
- R7: On `tx_done` with buffer-empty at 0, the held byte is loaded as in R5. On `tx_done` with buffer-empty at 1, idle is set and `irq_tx_idle` rises if idle irq enable is 1.
- R8: A received byte while receive-full is 0 is stored and sets receive-full. It pulses `irq_rx_full` if receive/error irq enable is set.
- R9: A received byte while receive-full is 1 sets overrun, keeps the stored byte, and raises `irq_err` if receive/error irq enable is set.
- R10: Reading the receive byte clears receive-full.
- R11: A line break sets framing error and raises `irq_err` if receive/error irq enable is set.
- R12: An error bit clears only when 0 is written to it after a status read has shown it as 1 since it last became set. `irq_err` falls once all three error bits are 0.
- R13: A control write with idle irq enable 0 drops `irq_tx_idle`. A control write with receive/error irq enable 0 drops `irq_err`.
- R14: A write to the receive-byte offset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| cfg_mode | output | 8 | Line mode register to the frame engine |
| cfg_rate | output | 8 | Bit-rate register to the frame engine |
| cfg_tx_en | output | 1 | Transmit enable |
| cfg_rx_en | output | 1 | Receive enable |
| tx_load | output | 1 | One-cycle strobe: start sending `tx_byte` |
| tx_byte | output | 8 | Byte to send |
| tx_done | input | 1 | Frame engine finished a frame |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_break | input | 1 | Line break detected |
| irq_rx_full | output | 1 | Receive interrupt pulse |
| irq_tx_empty | output | 1 | Transmit buffer empty interrupt pulse |
| irq_tx_idle | output | 1 | Transmitter idle interrupt level |
| irq_err | output | 1 | Receive error interrupt level |

## Verification
The transmit path is swept over all four combinations of its two interrupt enables. Each combination runs an immediate send, a parked second byte and two frame completions, which separates the idle-start path from the buffered path and shows each interrupt following only its own enable. The receive path runs with its interrupt enable on and off through a clean byte, an overrun, a break, and a mix of one error seen by a status read and one not yet seen. That last case tells apart a clear that needs a prior read from one that does not. The configuration lock is swept over all four combinations of the two direction enables, with distinct values written each time.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int NERR = 3;

  typedef enum logic [AW-1:0] {
    A_MODE = 3'd0,
    A_RATE = 3'd1,
    A_CTRL = 3'd2,
    A_TXD  = 3'd3,
    A_STAT = 3'd4,
    A_RXD  = 3'd5,
    A_AUXA = 3'd6,
    A_AUXB = 3'd7
  } reg_addr_e;

  // control bit positions
  localparam int C_IE_IDLE  = 2;
  localparam int C_RX_EN    = 4;
  localparam int C_TX_EN    = 5;
  localparam int C_IE_RX    = 6;
  localparam int C_IE_EMPTY = 7;

  // status bit positions
  localparam int S_MPTX  = 0;
  localparam int S_MPRX  = 1;
  localparam int S_IDLE  = 2;
  localparam int S_ERR0  = 3;
  localparam int S_FULL  = 6;
  localparam int S_EMPTY = 7;

  // error vector index (err[i] sits at status bit S_ERR0+i)
  localparam int E_PAR = 0;
  localparam int E_FRM = 1;
  localparam int E_OVR = 2;

  localparam logic [DW-1:0] RST_MODE = 8'h00;
  localparam logic [DW-1:0] RST_RATE = 8'hFF;
  localparam logic [DW-1:0] RST_CTRL = 8'h00;
  localparam logic [DW-1:0] RST_TXD  = 8'hFF;
  localparam logic [DW-1:0] RST_RXD  = 8'h00;
  localparam logic [DW-1:0] RST_AUX  = 8'h00;
endpackage

// File: rtl/sio_tx_flags.sv
module sio_tx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic tx_en_new,
  input  logic ie_empty,
  input  logic ie_idle,
  input  logic txd_wr,
  input  logic tx_done,
  output logic tx_empty_q,
  output logic tx_idle_q,
  output logic tx_load_q,
  output logic irq_empty_q,
  output logic irq_idle_q
);
  logic empty_d, idle_d, load_d, irq_empty_d, irq_idle_d;

  always_comb begin
    empty_d     = tx_empty_q;
    idle_d      = tx_idle_q;
    load_d      = 1'b0;
    irq_empty_d = 1'b0;
    irq_idle_d  = irq_idle_q;
    // bus side first
    if (ctrl_wr && tx_en_new) begin
      empty_d = 1'b1;
      idle_d  = 1'b1;
      if (ie_empty) irq_empty_d = 1'b1;
    end
    if (ctrl_wr && !ie_idle) irq_idle_d = 1'b0;
    if (txd_wr) begin
      if (tx_idle_q) begin
        load_d      = 1'b1;
        idle_d      = 1'b0;
        empty_d     = 1'b1;
        irq_idle_d  = 1'b0;
        if (ie_empty) irq_empty_d = 1'b1;
      end else begin
        empty_d = 1'b0;
      end
    end
    // then the frame engine
    if (tx_done) begin
      if (!empty_d) begin
        load_d      = 1'b1;
        idle_d      = 1'b0;
        empty_d     = 1'b1;
        irq_idle_d  = 1'b0;
        if (ie_empty) irq_empty_d = 1'b1;
      end else begin
        idle_d = 1'b1;
        if (ie_idle) irq_idle_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_empty_q  <= 1'b1;
      tx_idle_q   <= 1'b1;
      tx_load_q   <= 1'b0;
      irq_empty_q <= 1'b0;
      irq_idle_q  <= 1'b0;
    end else begin
      tx_empty_q  <= empty_d;
      tx_idle_q   <= idle_d;
      tx_load_q   <= load_d;
      irq_empty_q <= irq_empty_d;
      irq_idle_q  <= irq_idle_d;
    end
  end
endmodule

// File: rtl/sio_rx_flags.sv
module sio_rx_flags
  import sio_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctrl_wr,
  input  logic            ie_rx,
  input  logic            stat_rd,
  input  logic            stat_wr,
  input  logic [NERR-1:0] stat_wbits,
  input  logic            rxd_rd,
  input  logic            rx_valid,
  input  logic [DW-1:0]   rx_byte,
  input  logic            rx_break,
  output logic            rx_full_q,
  output logic [NERR-1:0] err_q,
  output logic [DW-1:0]   rxd_q,
  output logic            irq_rx_q,
  output logic            irq_err_q
);
  logic [NERR-1:0] err_d, seen_q, seen_d;
  logic            full_d, irq_rx_d, irq_err_d, rxd_en;

  always_comb begin
    full_d    = rx_full_q;
    err_d     = err_q;
    seen_d    = seen_q;
    irq_err_d = irq_err_q;
    irq_rx_d  = 1'b0;
    rxd_en    = 1'b0;
    if (stat_rd) seen_d = err_q;
    if (rxd_rd)  full_d = 1'b0;
    if (stat_wr) begin
      for (int i = 0; i < NERR; i++) begin
        if (!stat_wbits[i] && seen_q[i]) begin
          err_d[i]  = 1'b0;
          seen_d[i] = 1'b0;
        end
      end
      if (err_d == '0) irq_err_d = 1'b0;
    end
    if (ctrl_wr && !ie_rx) irq_err_d = 1'b0;
    if (rx_break) begin
      err_d[E_FRM] = 1'b1;
      if (ie_rx) irq_err_d = 1'b1;
    end
    if (rx_valid) begin
      if (full_d) begin
        err_d[E_OVR] = 1'b1;
        if (ie_rx) irq_err_d = 1'b1;
      end else begin
        rxd_en   = 1'b1;
        full_d   = 1'b1;
        irq_rx_d = ie_rx;
      end
    end
    // a freshly set error has not been seen yet
    seen_d = seen_d & ~(err_d & ~err_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full_q <= 1'b0;
      err_q     <= '0;
      seen_q    <= '0;
      irq_rx_q  <= 1'b0;
      irq_err_q <= 1'b0;
    end else begin
      rx_full_q <= full_d;
      err_q     <= err_d;
      seen_q    <= seen_d;
      irq_rx_q  <= irq_rx_d;
      irq_err_q <= irq_err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rxd_q <= RST_RXD;
    else if (rxd_en) rxd_q <= rx_byte;
  end
endmodule

// File: rtl/sio_regs.sv
module sio_regs
  import sio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] cfg_mode,
  output logic [DW-1:0] cfg_rate,
  output logic          cfg_tx_en,
  output logic          cfg_rx_en,
  output logic          tx_load,
  output logic [DW-1:0] tx_byte,
  input  logic          tx_done,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_break,
  output logic          irq_rx_full,
  output logic          irq_tx_empty,
  output logic          irq_tx_idle,
  output logic          irq_err
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic          wr_en, rd_en, cfg_lock;
  logic          mode_wr, rate_wr, ctrl_wr, txd_wr, stat_wr, auxa_wr, auxb_wr;
  logic          stat_rd, rxd_rd;
  logic [DW-1:0] mode_q, rate_q, ctrl_q, txd_q, auxa_q, auxb_q;
  logic [DW-1:0] ctrl_eff;
  logic          mptx_q;
  logic          tx_empty_q, tx_idle_q, rx_full_q;
  logic [NERR-1:0] err_q;
  logic [DW-1:0] rxd_q, stat_v;

  assign wr_en    = bus_sel & bus_wr;
  assign rd_en    = bus_sel & ~bus_wr;
  assign cfg_lock = ctrl_q[C_TX_EN] | ctrl_q[C_RX_EN];

  assign mode_wr = wr_en && (bus_addr == A_MODE) && !cfg_lock;
  assign rate_wr = wr_en && (bus_addr == A_RATE) && !cfg_lock;
  assign ctrl_wr = wr_en && (bus_addr == A_CTRL);
  assign txd_wr  = wr_en && (bus_addr == A_TXD);
  assign stat_wr = wr_en && (bus_addr == A_STAT);
  assign auxa_wr = wr_en && (bus_addr == A_AUXA);
  assign auxb_wr = wr_en && (bus_addr == A_AUXB);
  assign stat_rd = rd_en && (bus_addr == A_STAT);
  assign rxd_rd  = rd_en && (bus_addr == A_RXD);

  // control value in force for this cycle's events
  assign ctrl_eff = ctrl_wr ? bus_wdata : ctrl_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q <= RST_MODE;
      rate_q <= RST_RATE;
      ctrl_q <= RST_CTRL;
      txd_q  <= RST_TXD;
      auxa_q <= RST_AUX;
      auxb_q <= RST_AUX;
      mptx_q <= 1'b0;
    end else begin
      if (mode_wr) mode_q <= bus_wdata;
      if (rate_wr) rate_q <= bus_wdata;
      if (ctrl_wr) ctrl_q <= bus_wdata;
      if (txd_wr)  txd_q  <= bus_wdata;
      if (auxa_wr) auxa_q <= bus_wdata;
      if (auxb_wr) auxb_q <= bus_wdata;
      if (stat_wr) mptx_q <= bus_wdata[S_MPTX];
    end
  end

  sio_tx_flags u_tx (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ctrl_wr    (ctrl_wr),
    .tx_en_new  (bus_wdata[C_TX_EN]),
    .ie_empty   (ctrl_eff[C_IE_EMPTY]),
    .ie_idle    (ctrl_eff[C_IE_IDLE]),
    .txd_wr     (txd_wr),
    .tx_done    (tx_done),
    .tx_empty_q (tx_empty_q),
    .tx_idle_q  (tx_idle_q),
    .tx_load_q  (tx_load),
    .irq_empty_q(irq_tx_empty),
    .irq_idle_q (irq_tx_idle)
  );

  sio_rx_flags u_rx (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ctrl_wr   (ctrl_wr),
    .ie_rx     (ctrl_eff[C_IE_RX]),
    .stat_rd   (stat_rd),
    .stat_wr   (stat_wr),
    .stat_wbits(bus_wdata[S_ERR0 +: NERR]),
    .rxd_rd    (rxd_rd),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .rx_break  (rx_break),
    .rx_full_q (rx_full_q),
    .err_q     (err_q),
    .rxd_q     (rxd_q),
    .irq_rx_q  (irq_rx_full),
    .irq_err_q (irq_err)
  );

  always_comb begin
    stat_v                    = '0;
    stat_v[S_MPTX]            = mptx_q;
    stat_v[S_MPRX]            = 1'b0;
    stat_v[S_IDLE]            = tx_idle_q;
    stat_v[S_ERR0 +: NERR]    = err_q;
    stat_v[S_FULL]            = rx_full_q;
    stat_v[S_EMPTY]           = tx_empty_q;
  end

  always_comb begin
    unique case (bus_addr)
      A_MODE: bus_rdata = mode_q;
      A_RATE: bus_rdata = rate_q;
      A_CTRL: bus_rdata = ctrl_q;
      A_TXD:  bus_rdata = txd_q;
      A_STAT: bus_rdata = stat_v;
      A_RXD:  bus_rdata = rxd_q;
      A_AUXA: bus_rdata = auxa_q;
      A_AUXB: bus_rdata = auxb_q;
      default: bus_rdata = '1;
    endcase
  end

  assign cfg_mode  = mode_q;
  assign cfg_rate  = rate_q;
  assign cfg_tx_en = ctrl_q[C_TX_EN];
  assign cfg_rx_en = ctrl_q[C_RX_EN];
  assign tx_byte   = txd_q;
endmodule

// File: rtl/sio_regs_chk.sv
module sio_regs_chk
  import sio_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            bus_sel,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   cfg_mode,
  input logic            cfg_tx_en,
  input logic            cfg_rx_en,
  input logic            tx_load,
  input logic            tx_empty,
  input logic            tx_idle,
  input logic            rx_valid,
  input logic            rx_full,
  input logic [NERR-1:0] err,
  input logic [DW-1:0]   ctrl,
  input logic            irq_rx_full,
  input logic            irq_tx_idle,
  input logic            irq_err
);
  p_mode_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == A_MODE && (cfg_tx_en || cfg_rx_en))
      |=> $stable(cfg_mode));

  p_load_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> (tx_empty && !tx_idle));

  p_idle_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx_idle |-> (tx_idle && ctrl[C_IE_IDLE]));

  p_rx_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_full |-> rx_full);

  p_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_full && !(bus_sel && !bus_wr && bus_addr == A_RXD))
      |=> err[E_OVR]);

  p_err_irq_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> ((err != '0) && ctrl[C_IE_RX]));
endmodule

bind sio_regs sio_regs_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .cfg_mode   (cfg_mode),
  .cfg_tx_en  (cfg_tx_en),
  .cfg_rx_en  (cfg_rx_en),
  .tx_load    (tx_load),
  .tx_empty   (tx_empty_q),
  .tx_idle    (tx_idle_q),
  .rx_valid   (rx_valid),
  .rx_full    (rx_full_q),
  .err        (err_q),
  .ctrl       (ctrl_q),
  .irq_rx_full(irq_rx_full),
  .irq_tx_idle(irq_tx_idle),
  .irq_err    (irq_err)
);

// File: tb/sio_regs_bench.sv
module sio_regs_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] cfg_mode, cfg_rate, tx_byte, rx_byte = '0;
  logic       cfg_tx_en, cfg_rx_en, tx_load;
  logic       tx_done = 1'b0, rx_valid = 1'b0, rx_break = 1'b0;
  logic       irq_rx_full, irq_tx_empty, irq_tx_idle, irq_err;
  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  sio_regs u_sio_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_mode(cfg_mode), .cfg_rate(cfg_rate), .cfg_tx_en(cfg_tx_en),
    .cfg_rx_en(cfg_rx_en), .tx_load(tx_load), .tx_byte(tx_byte),
    .tx_done(tx_done), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_break(rx_break), .irq_rx_full(irq_rx_full),
    .irq_tx_empty(irq_tx_empty), .irq_tx_idle(irq_tx_idle), .irq_err(irq_err)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic rdchk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic rx(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic brk();
    @(negedge clk); rx_break = 1;
    @(negedge clk); rx_break = 0;
  endtask

  task automatic fin();
    @(negedge clk); tx_done = 1;
    @(negedge clk); tx_done = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rst_exp [8];
    logic [7:0] m_mode, m_rate, cv, b;
    rst_exp = '{8'h00, 8'hFF, 8'h00, 8'hFF, 8'h84, 8'h00, 8'h00, 8'h00};
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset values over the whole map
    for (int a = 0; a < 8; a++) rdchk("R1 reset read", 3'(a), rst_exp[a]);
    chk("R1 reset irqs", {4'h0, irq_rx_full, irq_tx_empty, irq_tx_idle, irq_err}, 8'h00);
    wr(3'd6, 8'h3C); rdchk("R1 aux A", 3'd6, 8'h3C);
    wr(3'd7, 8'hC3); rdchk("R1 aux B", 3'd7, 8'hC3);

    // R3: lock over all enable combinations
    m_mode = 8'h00; m_rate = 8'hFF;
    for (int c = 0; c < 4; c++) begin
      cv = 8'((c & 1) << 4) | 8'(((c >> 1) & 1) << 5);
      wr(3'd2, cv);
      wr(3'd0, 8'h10 + 8'(c));
      wr(3'd1, 8'h20 + 8'(c));
      if (c == 0) begin m_mode = 8'h10; m_rate = 8'h20; end
      rdchk("R3 mode lock", 3'd0, m_mode);
      rdchk("R3 rate lock", 3'd1, m_rate);
      chk("R3 cfg_mode port", cfg_mode, m_mode);
      wr(3'd2, 8'h00);
    end

    // R2: multiprocessor transmit bit in status bit 0
    wr(3'd4, 8'h01); rdchk("R2 status bit0 set", 3'd4, 8'h85);
    wr(3'd4, 8'h00); rdchk("R2 status bit0 clear", 3'd4, 8'h84);

    // R4..R7, R13: transmit sweep over both interrupt enables
    for (int k = 0; k < 4; k++) begin
      logic tie, teie;
      tie = k[0]; teie = k[1];
      cv = 8'h20 | (8'(tie) << 7) | (8'(teie) << 2);
      wr(3'd2, cv);
      chk("R4 enable pulse", {7'd0, irq_tx_empty}, {7'd0, tie});
      rdchk("R4 flags after enable", 3'd4, 8'h84);
      wr(3'd3, 8'hA0 + 8'(k));
      chk("R5 load strobe", {7'd0, tx_load}, 8'h01);
      chk("R5 load byte", tx_byte, 8'hA0 + 8'(k));
      chk("R5 empty irq", {7'd0, irq_tx_empty}, {7'd0, tie});
      rdchk("R5 status", 3'd4, 8'h80);
      wr(3'd3, 8'hB0 + 8'(k));
      chk("R6 no load", {7'd0, tx_load}, 8'h00);
      rdchk("R6 status", 3'd4, 8'h00);
      fin();
      chk("R7 buffered load", {7'd0, tx_load}, 8'h01);
      chk("R7 buffered byte", tx_byte, 8'hB0 + 8'(k));
      chk("R7 empty irq", {7'd0, irq_tx_empty}, {7'd0, tie});
      rdchk("R7 status after reload", 3'd4, 8'h80);
      fin();
      chk("R7 no load at end", {7'd0, tx_load}, 8'h00);
      chk("R7 idle irq", {7'd0, irq_tx_idle}, {7'd0, teie});
      rdchk("R7 status idle", 3'd4, 8'h84);
      wr(3'd2, 8'h20);
      chk("R13 idle irq dropped", {7'd0, irq_tx_idle}, 8'h00);
      wr(3'd2, 8'h00);
    end

    // R8..R12, R13: receive sweep over interrupt enable
    for (int r = 0; r < 2; r++) begin
      logic rie;
      rie = r[0];
      wr(3'd2, 8'h10 | (8'(rie) << 6));
      rx(8'h5A + 8'(r));
      chk("R8 rx irq", {7'd0, irq_rx_full}, {7'd0, rie});
      rx(8'h33);
      chk("R9 overrun irq", {7'd0, irq_err}, {7'd0, rie});
      wr(3'd4, 8'h00);
      rdchk("R12 unseen overrun kept", 3'd4, 8'hE4);
      chk("R12 irq kept", {7'd0, irq_err}, {7'd0, rie});
      rdchk("R9 data kept", 3'd5, 8'h5A + 8'(r));
      rdchk("R10 full cleared", 3'd4, 8'hA4);
      wr(3'd4, 8'h00);
      rdchk("R12 seen overrun cleared", 3'd4, 8'h84);
      chk("R12 irq dropped", {7'd0, irq_err}, 8'h00);
      brk();
      chk("R11 break irq", {7'd0, irq_err}, {7'd0, rie});
      rdchk("R11 framing set", 3'd4, 8'h94);
      rx(8'h61); rx(8'h62);
      wr(3'd4, 8'h00);
      rdchk("R12 only seen bit cleared", 3'd4, 8'hE4);
      chk("R12 irq held by overrun", {7'd0, irq_err}, {7'd0, rie});
      wr(3'd2, 8'h10);
      chk("R13 err irq dropped", {7'd0, irq_err}, 8'h00);
      wr(3'd4, 8'h00);
      rdchk("R12 all clear", 3'd4, 8'hC4);
      rdchk("R10 byte", 3'd5, 8'h61);
      wr(3'd2, 8'h00);
    end

    // R14: write to receive offset ignored
    rx(8'h11);
    wr(3'd5, 8'h77);
    rdchk("R14 full untouched", 3'd4, 8'hC4);
    rd(3'd5, b);
    chk("R14 data untouched", b, 8'h11);

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule